// File: doc/BRIEF.md
# Capture Channel Packet Matcher

This block watches a stream of already-decoded camera packet events (frame start, frame end, line start, line end and long data packets). Each event carries a stream index, a virtual-channel index and a 6-bit data type. The block decides which events belong to one capture channel. Each of the three tags is checked against a programmed value under a mask, and only events that pass all three checks are forwarded downstream, one cycle later. When override is enabled, the forwarded data type is replaced by a programmed substitute. This lets a byte-oriented user-defined type be handed on as an ordinary one.

For matched events the block keeps three saturating counters and packs them into one status word: frame starts, frame ends and faulty frame ends. A small frame tracker runs in two states, `ST_IDLE` (no frame open) and `ST_OPEN` (a frame start has been seen). It has four transitions:
- `T_START`: a frame start in `ST_IDLE` moves to `ST_OPEN`.
- `T_RESTART`: a frame start in `ST_OPEN` stays in `ST_OPEN` and resets the line count.
- `T_CLOSE`: a frame end in `ST_OPEN` returns to `ST_IDLE`.
- `T_ORPHAN`: a frame end in `ST_IDLE` stays in `ST_IDLE` and is always faulty.

In `ST_OPEN`, matched line starts are counted. A `T_CLOSE` is faulty when that count differs from the programmed height.

A single write/read port configures the matcher and reads back the counters. Reads are combinational on the address.

Top module: `ccm_chan_matcher`

## Requirements
- R1: After reset, the registers read as follows: address 0 reads 0x3F0F, address 1 reads 0x03F, address 2 reads 0x5C (override disabled, substitute 0x2E), addresses 3 to 5 read 0, and no event is forwarded or counted.
- R2: The stream match is at address 0. Bits 19:14 hold the one-hot wanted-stream value and bits 13:8 hold its mask. Stream index n has the one-hot form with bit n set, and an index of 6 or 7 has the one-hot form 0. The check passes when (one-hot XOR value) AND mask is zero.
- R3: The virtual-channel match is also at address 0. Bits 7:4 hold the one-hot value and bits 3:0 hold the mask. It uses the same masked rule as R2, so a mask of 0 accepts every channel.
- R4: The data-type match is at address 1. Bits 11:6 hold the wanted type and bits 5:0 hold the mask. The check passes when (incoming type XOR value) AND mask is zero.
- R5: The override register is at address 2. Bit 0 enables override and bits 6:1 hold the substitute type. Matching always uses the incoming type. A forwarded event carries the substitute type when override is enabled and the incoming type otherwise.
- R6: An event that passes all three checks appears on the forward outputs in the next cycle with its kind code unchanged (0 frame start, 1 frame end, 2 line start, 3 line end, 4 long). Any other event is not forwarded.
- R7: The status word is at address 5. Bits 11:0 count matched frame starts, bits 23:12 count matched frame ends and bits 31:24 count faulty frame ends. Non-matching events change none of them.
- R8: The start and end counts stop at 4095 and the faulty count stops at 255. None of them wraps.
- R9: A matched frame end is faulty when no frame is open, or when the number of matched line starts since the frame start differs from the height register at address 4.
- R10: Any write to address 5 clears all three counts. When a matched event arrives in the same cycle as that write, the clear wins and the counts read 0 afterwards.
- R11: A frame start while a frame is already open restarts the line count at zero.
- R12: The width and height registers at addresses 3 and 4 read back exactly the 32-bit values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 3 | Event kind code |
| ev_stream | input | 3 | Stream index |
| ev_vc | input | 2 | Virtual-channel index |
| ev_dt | input | 6 | Packet data type |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for write and read |
| cfg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed register |
| fwd_valid | output | 1 | Matched event forwarded |
| fwd_kind | output | 3 | Kind of forwarded event |
| fwd_dt | output | 6 | Data type of forwarded event, after override |

## Verification
Two functions can land in the same cycle: a matched event that would advance the counters, and a register write that clears them. The bench drives a matched frame start in the same cycle as a write to the status address. It judges the result by reading the status word on the next cycle, where all three counts must be zero. The behavioural model, compared on every clock, applies the clear after the event's increment. In the same way, configuration writes that share a cycle with events must act only on later events.

// File: rtl/ccm_pkg.sv
`timescale 1ns/1ps
package ccm_pkg;
    typedef enum logic [2:0] {
        EV_FS   = 3'd0,
        EV_FE   = 3'd1,
        EV_LS   = 3'd2,
        EV_LE   = 3'd3,
        EV_LONG = 3'd4
    } ev_kind_t;

    localparam logic [2:0] A_CHMATCH = 3'd0;
    localparam logic [2:0] A_DTMATCH = 3'd1;
    localparam logic [2:0] A_OVRD    = 3'd2;
    localparam logic [2:0] A_XDIM    = 3'd3;
    localparam logic [2:0] A_YDIM    = 3'd4;
    localparam logic [2:0] A_STATUS  = 3'd5;

    localparam logic [5:0] DT_SUBST_RST = 6'h2e;
endpackage

// File: rtl/ccm_field_match.sv
`timescale 1ns/1ps
module ccm_field_match #(
    parameter int W = 6
) (
    input  logic [W-1:0] key,
    input  logic [W-1:0] want,
    input  logic [W-1:0] care,
    output logic         hit
);
    assign hit = ~|((key ^ want) & care);
endmodule

// File: rtl/ccm_sat_cnt.sv
`timescale 1ns/1ps
module ccm_sat_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (clr)                cnt <= '0;
        else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ccm_frame_fsm.sv
`timescale 1ns/1ps
module ccm_frame_fsm #(
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_i,
    input  logic              fe_i,
    input  logic              ls_i,
    input  logic [LINE_W-1:0] height_i,
    output logic              fe_bad_o
);
    typedef enum logic {ST_IDLE, ST_OPEN} fr_state_t;

    localparam logic [LINE_W-1:0] LMAX = '1;

    fr_state_t         state, nxt;
    logic [LINE_W-1:0] lines;

    // next state: T_START, T_RESTART, T_CLOSE, T_ORPHAN
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (fs_i) nxt = ST_OPEN;
            ST_OPEN: if (fe_i) nxt = ST_IDLE;
        endcase
    end

    // state register and line count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            lines <= '0;
        end else begin
            state <= nxt;
            if (fs_i)
                lines <= '0;
            else if (ls_i && state == ST_OPEN && lines != LMAX)
                lines <= lines + 1'b1;
        end
    end

    // outputs
    always_comb begin
        fe_bad_o = 1'b0;
        unique case (state)
            ST_IDLE: fe_bad_o = fe_i;
            ST_OPEN: fe_bad_o = fe_i && (lines != height_i);
        endcase
    end
endmodule

// File: rtl/ccm_chan_matcher.sv
`timescale 1ns/1ps
module ccm_chan_matcher
    import ccm_pkg::*;
#(
    parameter int NSTREAM = 6,
    parameter int NVC     = 4,
    parameter int DT_W    = 6,
    parameter int DIM_W   = 32,
    parameter int CNT_W   = 12,
    parameter int BAD_W   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev_valid,
    input  logic [2:0]  ev_kind,
    input  logic [2:0]  ev_stream,
    input  logic [1:0]  ev_vc,
    input  logic [5:0]  ev_dt,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] rd_data,
    output logic        fwd_valid,
    output logic [2:0]  fwd_kind,
    output logic [5:0]  fwd_dt
);
    localparam int CH_W   = 2 * NSTREAM + 2 * NVC;
    localparam int DM_W   = 2 * DT_W;
    localparam int OV_W   = DT_W + 1;
    localparam int STAT_W = 2 * CNT_W + BAD_W;

    logic [NSTREAM-1:0] st_val, st_msk, stream_oh;
    logic [NVC-1:0]     vc_val, vc_msk, vc_oh;
    logic [DT_W-1:0]    dt_val, dt_msk, ovr_dt;
    logic               ovr_en;
    logic [DIM_W-1:0]   x_dim, y_dim;
    logic [CNT_W-1:0]   fs_cnt, fe_cnt;
    logic [BAD_W-1:0]   bad_cnt;
    logic [STAT_W-1:0]  status_w;
    logic               st_hit, vc_hit, dt_hit, hit, clr, fe_bad;

    for (genvar i = 0; i < NSTREAM; i++) begin : g_soh
        assign stream_oh[i] = (ev_stream == 3'(i));
    end
    for (genvar i = 0; i < NVC; i++) begin : g_voh
        assign vc_oh[i] = (ev_vc == 2'(i));
    end

    ccm_field_match #(.W(NSTREAM)) u_st (.key(stream_oh), .want(st_val), .care(st_msk), .hit(st_hit));
    ccm_field_match #(.W(NVC))     u_vc (.key(vc_oh),     .want(vc_val), .care(vc_msk), .hit(vc_hit));
    ccm_field_match #(.W(DT_W))    u_dt (.key(ev_dt),     .want(dt_val), .care(dt_msk), .hit(dt_hit));

    assign hit = ev_valid && st_hit && vc_hit && dt_hit;
    assign clr = cfg_we && (cfg_addr == A_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_val <= '0;  st_msk <= '1;
            vc_val <= '0;  vc_msk <= '1;
            dt_val <= '0;  dt_msk <= '1;
            ovr_en <= 1'b0; ovr_dt <= DT_SUBST_RST;
            x_dim  <= '0;  y_dim  <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                A_CHMATCH: {st_val, st_msk, vc_val, vc_msk} <= cfg_wdata[CH_W-1:0];
                A_DTMATCH: {dt_val, dt_msk} <= cfg_wdata[DM_W-1:0];
                A_OVRD:    {ovr_dt, ovr_en} <= cfg_wdata[OV_W-1:0];
                A_XDIM:    x_dim <= cfg_wdata[DIM_W-1:0];
                A_YDIM:    y_dim <= cfg_wdata[DIM_W-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (cfg_addr)
            A_CHMATCH: rd_data[CH_W-1:0]   = {st_val, st_msk, vc_val, vc_msk};
            A_DTMATCH: rd_data[DM_W-1:0]   = {dt_val, dt_msk};
            A_OVRD:    rd_data[OV_W-1:0]   = {ovr_dt, ovr_en};
            A_XDIM:    rd_data[DIM_W-1:0]  = x_dim;
            A_YDIM:    rd_data[DIM_W-1:0]  = y_dim;
            A_STATUS:  rd_data[STAT_W-1:0] = status_w;
            default:   ;
        endcase
    end

    ccm_frame_fsm #(.LINE_W(DIM_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .fs_i(hit && ev_kind == EV_FS),
        .fe_i(hit && ev_kind == EV_FE),
        .ls_i(hit && ev_kind == EV_LS),
        .height_i(y_dim),
        .fe_bad_o(fe_bad)
    );

    ccm_sat_cnt #(.W(CNT_W)) u_fs  (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(hit && ev_kind == EV_FS), .cnt(fs_cnt));
    ccm_sat_cnt #(.W(CNT_W)) u_fe  (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(hit && ev_kind == EV_FE), .cnt(fe_cnt));
    ccm_sat_cnt #(.W(BAD_W)) u_bad (.clk(clk), .rst_n(rst_n), .clr(clr), .inc(fe_bad), .cnt(bad_cnt));

    assign status_w = {bad_cnt, fe_cnt, fs_cnt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_kind  <= '0;
            fwd_dt    <= '0;
        end else begin
            fwd_valid <= hit;
            fwd_kind  <= ev_kind;
            fwd_dt    <= ovr_en ? ovr_dt : ev_dt;
        end
    end
endmodule

// File: rtl/ccm_check.sv
`timescale 1ns/1ps
module ccm_check #(
    parameter int CNT_W = 12,
    parameter int BAD_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ev_valid,
    input logic                       cfg_we,
    input logic [2:0]                 cfg_addr,
    input logic                       fwd_valid,
    input logic [5:0]                 fwd_dt,
    input logic                       ovr_en,
    input logic [5:0]                 ovr_dt,
    input logic [2*CNT_W+BAD_W-1:0]   status
);
    localparam int FE_LO  = CNT_W;
    localparam int BAD_LO = 2 * CNT_W;

    logic wipe;
    assign wipe = cfg_we && (cfg_addr == 3'd5);

    p_fwd_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(ev_valid));

    p_override_dt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && $past(ovr_en)) |-> (fwd_dt == $past(ovr_dt)));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (status == '0));

    p_fs_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[CNT_W-1:0] == '1 && !wipe) |=> (status[CNT_W-1:0] == '1));

    p_bad_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BAD_LO +: BAD_W] == '1 && !wipe) |=> (status[BAD_LO +: BAD_W] == '1));

    p_fe_monotone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wipe |=> (status[FE_LO +: CNT_W] >= $past(status[FE_LO +: CNT_W])));
endmodule

bind ccm_chan_matcher ccm_check #(.CNT_W(CNT_W), .BAD_W(BAD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .fwd_valid(fwd_valid), .fwd_dt(fwd_dt),
    .ovr_en(ovr_en), .ovr_dt(ovr_dt),
    .status(status_w)
);

// File: tb/sim_ccm_chan_matcher.sv
`timescale 1ns/1ps
module sim_ccm_chan_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_kind = '0;
    logic [2:0]  ev_stream = '0;
    logic [1:0]  ev_vc = '0;
    logic [5:0]  ev_dt = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd5;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rd_data;
    logic        fwd_valid;
    logic [2:0]  fwd_kind;
    logic [5:0]  fwd_dt;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ccm_chan_matcher u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_stream(ev_stream), .ev_vc(ev_vc), .ev_dt(ev_dt),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rd_data(rd_data), .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_dt(fwd_dt)
    );

    // reference model state
    bit [5:0]  m_stv, m_stm, m_dtv, m_dtm, m_odt;
    bit [3:0]  m_vcv, m_vcm;
    bit        m_oen;
    bit [31:0] m_x, m_y;
    int        m_fs, m_fe, m_bad, m_lines;
    bit        m_open;
    bit        e_fv;
    bit [2:0]  e_fk;
    bit [5:0]  e_fdt;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_hit(input bit [2:0] s, input bit [1:0] v, input bit [5:0] d);
        bit [5:0] so;
        bit [3:0] vo;
        so = (s < 6) ? (6'd1 << s) : 6'd0;
        vo = 4'd1 << v;
        return (((so ^ m_stv) & m_stm) == 0) && (((vo ^ m_vcv) & m_vcm) == 0)
            && (((d ^ m_dtv) & m_dtm) == 0);
    endfunction

    function automatic bit [31:0] m_rd(input bit [2:0] a);
        case (a)
            3'd0: return {12'd0, m_stv, m_stm, m_vcv, m_vcm};
            3'd1: return {20'd0, m_dtv, m_dtm};
            3'd2: return {25'd0, m_odt, m_oen};
            3'd3: return m_x;
            3'd4: return m_y;
            3'd5: return {m_bad[7:0], m_fe[11:0], m_fs[11:0]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input bit [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd5: return "R7";
            default: return "R12";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stv = 0; m_stm = 6'h3f; m_vcv = 0; m_vcm = 4'hf;
            m_dtv = 0; m_dtm = 6'h3f; m_oen = 0; m_odt = 6'h2e;
            m_x = 0; m_y = 0; m_fs = 0; m_fe = 0; m_bad = 0;
            m_open = 0; m_lines = 0; e_fv = 0;
        end else begin
            e_fv = ev_valid && m_hit(ev_stream, ev_vc, ev_dt);
            if (e_fv) begin
                e_fk  = ev_kind;
                e_fdt = m_oen ? m_odt : ev_dt;
                case (ev_kind)
                    3'd0: begin
                        m_open = 1; m_lines = 0;
                        if (m_fs < 4095) m_fs++;
                    end
                    3'd2: if (m_open) m_lines++;
                    3'd1: begin
                        if ((!m_open || m_lines != int'(m_y)) && m_bad < 255) m_bad++;
                        m_open = 0;
                        if (m_fe < 4095) m_fe++;
                    end
                    default: ;
                endcase
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: {m_stv, m_stm, m_vcv, m_vcm} = cfg_wdata[19:0];
                    3'd1: {m_dtv, m_dtm} = cfg_wdata[11:0];
                    3'd2: {m_odt, m_oen} = cfg_wdata[6:0];
                    3'd3: m_x = cfg_wdata;
                    3'd4: m_y = cfg_wdata;
                    3'd5: begin m_fs = 0; m_fe = 0; m_bad = 0; end
                    default: ;
                endcase
            end
        end
        #1;
        chk(rd_data == m_rd(cfg_addr), rd_tag(cfg_addr), rd_data, m_rd(cfg_addr));
        chk(fwd_valid == e_fv, "R6 fwd_valid", fwd_valid, e_fv);
        if (e_fv && fwd_valid) begin
            chk(fwd_kind == e_fk, "R6 fwd_kind", fwd_kind, e_fk);
            chk(fwd_dt == e_fdt, "R5 fwd_dt", fwd_dt, e_fdt);
        end
    end

    task automatic idle();
        @(negedge clk);
        ev_valid = 0; cfg_we = 0; cfg_addr = 3'd5;
    endtask

    task automatic put(input bit [2:0] k, input bit [2:0] s, input bit [1:0] v, input bit [5:0] d);
        @(negedge clk);
        cfg_we = 0; cfg_addr = 3'd5;
        ev_valid = 1; ev_kind = k; ev_stream = s; ev_vc = v; ev_dt = d;
    endtask

    task automatic wr(input bit [2:0] a, input bit [31:0] d);
        @(negedge clk);
        ev_valid = 0; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        idle();
    endtask

    task automatic rd_expect(input bit [2:0] a, input bit [31:0] e, input string tag);
        @(negedge clk);
        ev_valid = 0; cfg_we = 0; cfg_addr = a;
        #0.5;
        chk(rd_data == e, tag, rd_data, e);
        idle();
    endtask

    task automatic stat_expect(input bit [31:0] e, input string tag);
        chk(rd_data == e, tag, rd_data, e);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd_expect(3'd0, 32'h3f0f, "R1 chmatch");
        rd_expect(3'd1, 32'h03f,  "R1 dtmatch");
        rd_expect(3'd2, 32'h5c,   "R1 override");
        rd_expect(3'd4, 32'h0,    "R1 height");
        put(3'd0, 3'd0, 2'd0, 6'h00); idle();
        chk(fwd_valid == 0, "R1 no match after reset", fwd_valid, 0);
        stat_expect(32'h0, "R1 status");

        // configure: stream 2, vc 0, dt 0x2b, height 3
        wr(3'd0, 32'h13f1f);
        wr(3'd1, 32'h00aff);
        wr(3'd3, 32'd640);
        wr(3'd4, 32'd3);
        rd_expect(3'd3, 32'd640, "R12 width");

        // good frame
        put(3'd0, 3'd2, 2'd0, 6'h2b); idle();
        chk(fwd_valid == 1 && fwd_kind == 3'd0, "R6 forward FS", fwd_kind, 0);
        for (int i = 0; i < 3; i++) begin
            put(3'd2, 3'd2, 2'd0, 6'h2b);
            put(3'd4, 3'd2, 2'd0, 6'h2b);
            put(3'd3, 3'd2, 2'd0, 6'h2b);
        end
        put(3'd1, 3'd2, 2'd0, 6'h2b); idle();
        stat_expect(32'h00001001, "R7 good frame");

        // short frame
        put(3'd0, 3'd2, 2'd0, 6'h2b);
        put(3'd2, 3'd2, 2'd0, 6'h2b);
        put(3'd2, 3'd2, 2'd0, 6'h2b);
        put(3'd1, 3'd2, 2'd0, 6'h2b); idle();
        stat_expect(32'h01002002, "R9 line mismatch");

        // orphan end
        put(3'd1, 3'd2, 2'd0, 6'h2b); idle();
        stat_expect(32'h02003002, "R9 orphan end");

        // restart
        put(3'd0, 3'd2, 2'd0, 6'h2b);
        put(3'd2, 3'd2, 2'd0, 6'h2b);
        put(3'd0, 3'd2, 2'd0, 6'h2b);
        for (int i = 0; i < 3; i++) put(3'd2, 3'd2, 2'd0, 6'h2b);
        put(3'd1, 3'd2, 2'd0, 6'h2b); idle();
        stat_expect(32'h02004004, "R11 restart");

        // mismatches
        put(3'd0, 3'd1, 2'd0, 6'h2b); idle();
        chk(fwd_valid == 0, "R2 wrong stream", fwd_valid, 0);
        put(3'd0, 3'd6, 2'd0, 6'h2b); idle();
        chk(fwd_valid == 0, "R2 out of range stream", fwd_valid, 0);
        put(3'd0, 3'd2, 2'd1, 6'h2b); idle();
        chk(fwd_valid == 0, "R3 wrong vc", fwd_valid, 0);
        put(3'd0, 3'd2, 2'd0, 6'h2c); idle();
        chk(fwd_valid == 0, "R4 wrong dt", fwd_valid, 0);
        stat_expect(32'h02004004, "R7 ignored events");

        // vc don't care
        wr(3'd0, 32'h13f10);
        put(3'd0, 3'd2, 2'd3, 6'h2b);
        put(3'd1, 3'd2, 2'd2, 6'h2b); idle();
        stat_expect(32'h03005005, "R3 vc mask zero");

        // override
        wr(3'd1, 32'h00c3f);
        wr(3'd2, 32'h55);
        put(3'd4, 3'd2, 2'd0, 6'h30); idle();
        chk(fwd_valid && fwd_dt == 6'h2a, "R5 override dt", fwd_dt, 6'h2a);
        put(3'd4, 3'd2, 2'd0, 6'h2a); idle();
        chk(fwd_valid == 0, "R5 match on incoming", fwd_valid, 0);
        wr(3'd2, 32'h54);
        put(3'd4, 3'd2, 2'd0, 6'h30); idle();
        chk(fwd_valid && fwd_dt == 6'h30, "R5 override off", fwd_dt, 6'h30);
        wr(3'd1, 32'h00c30);
        put(3'd4, 3'd2, 2'd0, 6'h3f); idle();
        chk(fwd_valid == 1, "R4 dt mask partial", fwd_valid, 1);

        // clear collides with event
        @(negedge clk);
        ev_valid = 1; ev_kind = 3'd0; ev_stream = 3'd2; ev_vc = 2'd0; ev_dt = 6'h30;
        cfg_we = 1; cfg_addr = 3'd5; cfg_wdata = 0;
        idle();
        stat_expect(32'h0, "R10 clear wins");

        // saturation
        for (int i = 0; i < 4100; i++) put(3'd0, 3'd2, 2'd0, 6'h30);
        idle();
        stat_expect(32'h00000fff, "R8 fs saturates");
        for (int i = 0; i < 4100; i++) put(3'd1, 3'd2, 2'd0, 6'h30);
        idle();
        stat_expect(32'hffffffff, "R8 fe and bad saturate");
        wr(3'd5, 32'h0);
        stat_expect(32'h0, "R10 plain clear");

        repeat (4) idle();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule